// File: doc/BRIEF.md
# Complex Multiply-Accumulate with Round-Bit Seeding

This block is the arithmetic core of a vector signal-processing engine. It keeps one accumulator split into a real half and an imaginary half, each 34 bits wide. On every clock that carries a valid element, it multiplies the X and Y operands and adds the products into the accumulator. A 16-bit result is read back by truncating a fixed window of the accumulator. Operands are 16-bit two's complement Q15 values. A product is a Q30 value, sign-extended to the width of the accumulator.

Rounding does not add a constant at the output. When a vector starts with the clear control set, the accumulator is loaded with the rounding bit placed at bit 14, and the products are added on top of it. The store simply truncates. When a vector starts with the clear control low, the accumulation continues from the value already held, and no new rounding bit is planted. Complex elements are added in a fixed order: first the partial products formed with the real part of X, then those formed with the imaginary part of X. Overflow is judged after each of these two additions.

Top module: `cmac_round_acc`

## Requirements
- R1: While reset is high, both accumulator halves and the overflow flag are cleared, so both result ports read 0 and the flag reads 0.
- R2: An element with valid, start and clear all high first sets both halves to a seed, then adds that element's products. The seed is 2^14 when rounding is enabled and the type is a rounding type, and 0 otherwise.
- R3: An element that is not a valid start-with-clear adds its products to the value already held, and plants no rounding bit. This applies to a start with clear low, and to any element that is not a start.
- R4: Type codes are 0 integer, 1 real, 2 aligned real, 3 complex and 4 extended. Only codes 1, 2 and 3 are rounding types. For codes 0 and 4 the round control has no effect.
- R5: For type 3, the real half gains x_re*y_re - x_im*y_im, and the imaginary half gains x_re*y_im + x_im*y_re.
- R6: For type 3, the partial products that use x_re are added to each half first. The products that use x_im are added afterwards. Overflow is tested after each of the two additions.
- R7: For any type other than 3, the single product x_re*y_re is added into both the real half and the imaginary half.
- R8: res_im is always bits [30:15] of the imaginary half. res_re is bits [30:15] of the imaginary half for type 4, and bits [30:15] of the real half for every other type. Both use plain truncation.
- R9: The overflow flag is set when any addition leaves the signed 34-bit range of a half. It stays set until a valid start-with-clear element, and that element's own additions can set it again.
- R10: When in_valid is low, the accumulator and the flag hold their values. Start, clear, round and operand inputs are ignored on such cycles.
- R11: Valid elements on consecutive clocks are each accumulated, one per clock, with no stall. The result of an element appears on the ports after the clock edge that takes it in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element present this cycle |
| vec_start | input | 1 | First element of a vector |
| acc_clear | input | 1 | At vector start, reseed instead of continuing |
| round_en | input | 1 | Rounding control planted into the seed |
| dtype | input | 3 | Data type code (see R4) |
| x_re | input | 16 | Real part of X operand, Q15 |
| x_im | input | 16 | Imaginary part of X operand, Q15 |
| y_re | input | 16 | Real part of Y operand, Q15 |
| y_im | input | 16 | Imaginary part of Y operand, Q15 |
| res_re | output | 16 | Truncated store value for real or extended results |
| res_im | output | 16 | Truncated store value of the imaginary half |
| ovf_flag | output | 1 | Sticky accumulator overflow |

## Verification
Some properties are checked on every cycle by assertions:
- idle cycles leave the accumulator and flag untouched;
- the flag stays set until a clearing start;
- a non-complex seeded element leaves identical halves;
- a seeded element with zero operands holds exactly the seed;
- zero operands on a continuing element change nothing.

Other behaviour can only be shown by the bench's scenarios. The bench sweeps every type code, with rounding on and off, through patterned operand sets that include the extreme Q15 values. It compares the results against an exact-integer model. Directed cases cover the rest: rounding visible through truncation, continuation without reseeding, and the overflow that only the real-then-imaginary order produces.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    localparam int OP_W    = 16;
    localparam int ACC_W   = 34;
    localparam int RND_BIT = 14;
    localparam int RES_LSB = 15;

    typedef enum logic [2:0] {
        DT_INT   = 3'd0,
        DT_REAL  = 3'd1,
        DT_AREAL = 3'd2,
        DT_CPLX  = 3'd3,
        DT_EXT   = 3'd4
    } dtype_e;

    // Only fractional types receive the planted rounding bit.
    function automatic logic dtype_rounds(input dtype_e t);
        return (t == DT_REAL) || (t == DT_AREAL) || (t == DT_CPLX);
    endfunction

endpackage

// File: rtl/cmac_prod.sv
module cmac_prod
    import cmac_pkg::*;
#(
    parameter int OP_W  = cmac_pkg::OP_W,
    parameter int ACC_W = cmac_pkg::ACC_W
) (
    input  logic signed [OP_W-1:0] x_re,
    input  logic signed [OP_W-1:0] x_im,
    input  logic signed [OP_W-1:0] y_re,
    input  logic signed [OP_W-1:0] y_im,
    input  dtype_e                 dt,
    output logic [ACC_W-1:0]       first_add  [2],
    output logic [ACC_W-1:0]       second_add [2]
);
    localparam int PW  = 2 * OP_W;
    localparam int XTW = ACC_W - PW;

    logic signed [PW-1:0] p_rr, p_ri, p_ir, p_ii;
    logic [ACC_W-1:0]     e_rr, e_ri, e_ir, e_ii;
    logic                 cplx;

    assign p_rr = PW'(x_re) * PW'(y_re);
    assign p_ri = PW'(x_re) * PW'(y_im);
    assign p_ir = PW'(x_im) * PW'(y_re);
    assign p_ii = PW'(x_im) * PW'(y_im);

    assign e_rr = {{XTW{p_rr[PW-1]}}, p_rr};
    assign e_ri = {{XTW{p_ri[PW-1]}}, p_ri};
    assign e_ir = {{XTW{p_ir[PW-1]}}, p_ir};
    assign e_ii = {{XTW{p_ii[PW-1]}}, p_ii};

    assign cplx = (dt == DT_CPLX);

    // First pass: terms built from the real part of X; second pass: imaginary part of X.
    always_comb begin
        first_add[0]  = e_rr;
        first_add[1]  = cplx ? e_ri : e_rr;
        second_add[0] = cplx ? (~e_ii + 1'b1) : '0;
        second_add[1] = cplx ? e_ir : '0;
    end

endmodule

// File: rtl/cmac_add_ovf.sv
module cmac_add_ovf #(
    parameter int W = cmac_pkg::ACC_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         wrapped
);
    assign sum     = a + b;
    assign wrapped = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/cmac_seed.sv
module cmac_seed
    import cmac_pkg::*;
#(
    parameter int ACC_W   = cmac_pkg::ACC_W,
    parameter int RND_BIT = cmac_pkg::RND_BIT
) (
    input  logic             fresh,
    input  logic             round_en,
    input  dtype_e           dt,
    input  logic [ACC_W-1:0] held     [2],
    input  logic             held_ovf,
    output logic [ACC_W-1:0] base     [2],
    output logic             base_ovf
);
    logic [ACC_W-1:0] seed_val;

    assign seed_val = {{(ACC_W-1){1'b0}}, (round_en && dtype_rounds(dt))} << RND_BIT;
    assign base_ovf = fresh ? 1'b0 : held_ovf;

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign base[h] = fresh ? seed_val : held[h];
    end

endmodule

// File: rtl/cmac_round_acc.sv
module cmac_round_acc
    import cmac_pkg::*;
#(
    parameter int OP_W    = cmac_pkg::OP_W,
    parameter int ACC_W   = cmac_pkg::ACC_W,
    parameter int RND_BIT = cmac_pkg::RND_BIT,
    parameter int RES_LSB = cmac_pkg::RES_LSB
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic                   vec_start,
    input  logic                   acc_clear,
    input  logic                   round_en,
    input  logic [2:0]             dtype,
    input  logic signed [OP_W-1:0] x_re,
    input  logic signed [OP_W-1:0] x_im,
    input  logic signed [OP_W-1:0] y_re,
    input  logic signed [OP_W-1:0] y_im,
    output logic [OP_W-1:0]        res_re,
    output logic [OP_W-1:0]        res_im,
    output logic                   ovf_flag
);
    localparam int RES_MSB = RES_LSB + OP_W - 1;

    dtype_e           dt;
    logic             fresh;
    logic [ACC_W-1:0] acc_q    [2];
    logic             ovf_q;
    logic [ACC_W-1:0] base     [2];
    logic             base_ovf;
    logic [ACC_W-1:0] add_a    [2];
    logic [ACC_W-1:0] add_b    [2];
    logic [ACC_W-1:0] mid      [2];
    logic [ACC_W-1:0] fin      [2];
    logic [1:0]       wrap_a;
    logic [1:0]       wrap_b;

    assign dt    = dtype_e'(dtype);
    assign fresh = in_valid && vec_start && acc_clear;

    cmac_seed #(.ACC_W(ACC_W), .RND_BIT(RND_BIT)) u_seed (
        .fresh    (fresh),
        .round_en (round_en),
        .dt       (dt),
        .held     (acc_q),
        .held_ovf (ovf_q),
        .base     (base),
        .base_ovf (base_ovf)
    );

    cmac_prod #(.OP_W(OP_W), .ACC_W(ACC_W)) u_prod (
        .x_re       (x_re),
        .x_im       (x_im),
        .y_re       (y_re),
        .y_im       (y_im),
        .dt         (dt),
        .first_add  (add_a),
        .second_add (add_b)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        cmac_add_ovf #(.W(ACC_W)) u_pass1 (
            .a(base[h]), .b(add_a[h]), .sum(mid[h]), .wrapped(wrap_a[h])
        );
        cmac_add_ovf #(.W(ACC_W)) u_pass2 (
            .a(mid[h]), .b(add_b[h]), .sum(fin[h]), .wrapped(wrap_b[h])
        );

        always_ff @(posedge clk) begin
            if (rst)
                acc_q[h] <= '0;
            else if (in_valid)
                acc_q[h] <= fin[h];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (in_valid)
            ovf_q <= base_ovf | (|wrap_a) | (|wrap_b);
    end

    assign res_re   = (dt == DT_EXT) ? acc_q[1][RES_MSB:RES_LSB] : acc_q[0][RES_MSB:RES_LSB];
    assign res_im   = acc_q[1][RES_MSB:RES_LSB];
    assign ovf_flag = ovf_q;

    // R10: an idle cycle changes nothing
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(acc_q[0]) && $stable(acc_q[1]) && $stable(ovf_q)));

    // R9: the flag survives until a clearing start
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(in_valid && vec_start && acc_clear)) |=> ovf_q);

    // R7: non-complex seeded element leaves identical halves
    p_mirror_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_start && acc_clear && dtype != 3'd3) |=> (acc_q[0] == acc_q[1]));

    // R2: zero operands after a seed leave exactly the seed
    p_round_seed_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vec_start && acc_clear && x_re == '0 && x_im == '0)
        |=> (acc_q[0] == ({{(ACC_W-1){1'b0}},
                           $past(round_en && dtype_rounds(dtype_e'(dtype)))} << RND_BIT)));

    // R3: continuing element with zero operands keeps the held value
    p_zero_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(vec_start && acc_clear) && x_re == '0 && x_im == '0)
        |=> ($stable(acc_q[0]) && $stable(acc_q[1])));

endmodule

// File: tb/cmac_round_acc_bench.sv
`timescale 1ns/100ps
module cmac_round_acc_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst, in_valid, vec_start, acc_clear, round_en;
    logic [2:0]         dtype;
    logic signed [15:0] x_re, x_im, y_re, y_im;
    logic [15:0]        res_re, res_im;
    logic               ovf_flag;

    cmac_round_acc u_cmac_round_acc (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vec_start(vec_start),
        .acc_clear(acc_clear), .round_en(round_en), .dtype(dtype),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .res_re(res_re), .res_im(res_im), .ovf_flag(ovf_flag)
    );

    int     checks = 0;
    int     errors = 0;
    longint m_re, m_im;
    bit     m_ovf;

    localparam longint LIM  = 64'sd1 <<< 33;
    localparam longint SPAN = 64'sd1 <<< 34;

    function automatic longint wrap34(input longint v);
        longint w;
        w = v & (SPAN - 1);
        if (w >= LIM) w = w - SPAN;
        return w;
    endfunction

    function automatic bit out_of_range(input longint v);
        return (v >= LIM) || (v < -LIM);
    endfunction

    function automatic logic [15:0] store_slice(input longint v);
        return v[30:15];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge, advance the model, compare at the next falling edge.
    task automatic step(input bit v, input bit s, input bit c, input bit r, input int t,
                        input int xr, input int yr, input int xi, input int yi,
                        input string tag);
        longint br, bi, a1, a2, b1, b2;
        bit     fresh, rnd_ty, ov;
        in_valid  = v;  vec_start = s;  acc_clear = c;  round_en = r;
        dtype     = 3'(t);
        x_re = 16'(xr); y_re = 16'(yr); x_im = 16'(xi); y_im = 16'(yi);
        if (v) begin
            fresh  = s && c;
            rnd_ty = (t == 1) || (t == 2) || (t == 3);
            br = fresh ? ((rnd_ty && r) ? 64'sd16384 : 64'sd0) : m_re;
            bi = fresh ? ((rnd_ty && r) ? 64'sd16384 : 64'sd0) : m_im;
            ov = fresh ? 1'b0 : m_ovf;
            if (t == 3) begin
                a1 = longint'(xr) * longint'(yr);  a2 = -(longint'(xi) * longint'(yi));
                b1 = longint'(xr) * longint'(yi);  b2 = longint'(xi) * longint'(yr);
            end else begin
                a1 = longint'(xr) * longint'(yr);  a2 = 0;
                b1 = a1;                           b2 = 0;
            end
            br = br + a1; ov |= out_of_range(br); br = wrap34(br);
            br = br + a2; ov |= out_of_range(br); br = wrap34(br);
            bi = bi + b1; ov |= out_of_range(bi); bi = wrap34(bi);
            bi = bi + b2; ov |= out_of_range(bi); bi = wrap34(bi);
            m_re = br; m_im = bi; m_ovf = ov;
        end
        @(negedge clk);
        chk({tag, " res_re"}, res_re, (t == 4) ? store_slice(m_im) : store_slice(m_re));
        chk({tag, " res_im"}, res_im, store_slice(m_im));
        chk({tag, " ovf"}, {15'd0, ovf_flag}, {15'd0, m_ovf});
    endtask

    function automatic int pick(input int k);
        case (k % 8)
            0: return -32768;
            1: return -32767;
            2: return -1;
            3: return 0;
            4: return 1;
            5: return 181;
            6: return 16384;
            default: return 32767;
        endcase
    endfunction

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R11 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 0; vec_start = 0; acc_clear = 0; round_en = 0;
        dtype = 3'd0; x_re = 0; x_im = 0; y_re = 0; y_im = 0;
        m_re = 0; m_im = 0; m_ovf = 0;
        repeat (3) @(negedge clk);
        chk("R1 reset res_re", res_re, 16'h0000);
        chk("R1 reset res_im", res_im, 16'h0000);
        chk("R1 reset ovf", {15'd0, ovf_flag}, 16'h0000);
        rst = 1'b0;

        // Rounding visible through truncation: product 2^14 plus seed 2^14 stores 1.
        step(1, 1, 1, 1, 1, 1, 16384, 0, 0, "R2 real rounded");
        chk("R2 rounded real value", res_re, 16'h0001);
        step(1, 1, 1, 0, 1, 1, 16384, 0, 0, "R2 real unrounded");
        chk("R2 unrounded real value", res_re, 16'h0000);
        step(1, 1, 1, 1, 0, 1, 16384, 0, 0, "R4 integer ignores round");
        chk("R4 integer value", res_re, 16'h0000);
        step(1, 1, 1, 1, 4, 1, 16384, 0, 0, "R4 extended ignores round");
        chk("R4 extended value", res_re, 16'h0000);

        // Continue from held seed, with no new injection.
        step(1, 1, 1, 1, 2, 0, 0, 0, 0, "R2 seed only");
        step(1, 1, 0, 0, 2, 1, 16384, 0, 0, "R3 continue uses old seed");
        chk("R3 continued value", res_re, 16'h0001);
        step(1, 1, 1, 0, 0, 0, 0, 0, 0, "R3 zero seed");
        step(1, 1, 0, 1, 1, 1, 16384, 0, 0, "R3 no reinjection");
        chk("R3 no reinjection value", res_re, 16'h0000);

        // Order test: real-X products push the real half past range first.
        step(1, 1, 1, 0, 3, -32768, -32768, 0, 0, "R6 preload");
        for (int i = 0; i < 6; i++)
            step(1, 0, 0, 0, 3, -32768, -32768, 0, 0, "R11 preload burst");
        chk("R6 no ovf yet", {15'd0, ovf_flag}, 16'h0000);
        step(1, 0, 0, 0, 3, -32768, -32768, 32767, 32767, "R6 order");
        chk("R6 interim ovf", {15'd0, ovf_flag}, 16'h0001);
        step(0, 1, 1, 1, 3, 5, 5, 5, 5, "R10 idle with start and clear");
        step(1, 0, 0, 0, 3, 1, 1, 1, 1, "R9 sticky");
        chk("R9 still set", {15'd0, ovf_flag}, 16'h0001);
        step(1, 1, 1, 0, 3, 1, 1, 1, 1, "R9 cleared");
        chk("R9 cleared value", {15'd0, ovf_flag}, 16'h0000);

        // Sweep every type with both round settings over patterned operands.
        for (int t = 0; t < 5; t++) begin
            for (int r = 0; r < 2; r++) begin
                for (int n = 0; n < 512; n++) begin
                    step(1, (n % 4) == 0, (n % 8) != 4, bit'(r), t,
                         pick(n), pick(n / 8), pick(n * 3 + 1), pick(n * 5 + 2),
                         (t == 3) ? "R5" : ((t == 4) ? "R8" : "R7"));
                    if ((n % 7) == 6)
                        step(0, 1, 1, bit'(r), t, pick(n + 1), 7, 9, 11, "R10");
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule